// File: doc/BRIEF.md
# Multi-mode parallel host bus front end

This block sits between an 8-bit microcontroller bus and an internal register/message store. Two static mode pins tell it how the host presents addresses. In the plain separate-bus style the address lines carry the address for the whole strobe. In the latched separate-bus style the address is captured from the address lines while a latch strobe is high. In the multiplexed style the data lines first carry the address under the latch strobe and then carry data. The fourth mode code hands the pins to a serial front end, and this block then stays idle.

Each falling read or write strobe, qualified by an active-low chip select, becomes one request on a request/grant port toward the internal store. While that request waits for its grant, an open-drain ready output is pulled low so the host stretches its cycle. Read data is driven back onto the data lines only once it has actually arrived. Host pins pass through a common register pipeline so that strobes, address and data stay aligned in system-clock time.

Top module: `hostbus_front`

## Requirements
- R1: With mode code 11 (serial), no strobe produces a request, the data bus is never driven and ready is never pulled low.
- R2: While chip select is high, read, write and latch strobes cause no internal access.
- R3: In mode 01 the address is taken from the address lines, and in mode 10 from the data lines, while the latch strobe is high. It is held after the latch strobe falls, even if those lines then change.
- R4: In mode 00 the address lines are sampled when the read or write strobe falls. Later changes during the same strobe have no effect.
- R5: A falling read or write strobe issues exactly one request. Its address, direction and write data stay fixed until the grant.
- R6: A write stores the value present on the data lines at the falling write strobe into the addressed location.
- R7: Ready is pulled low only while a request is outstanding and ungranted. It stays low for exactly as many cycles as the grant is delayed, and an immediate grant never pulls it low.
- R8: Read data is driven only while chip select and read strobe are low and the granted data has been captured. The driven value is the stored value at the addressed location.
- R9: After reset there is no request, ready is released and the data bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Static bus style: 00 plain separate, 01 latched separate, 10 multiplexed, 11 serial (block idle) |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address latch strobe, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr_in | input | AW | Dedicated address lines |
| ad_in | input | DW | Data lines as seen by the block (address too in mode 10) |
| ad_out | output | DW | Read data toward the data lines |
| ad_oe | output | 1 | Data line output enable |
| rdy_pull | output | 1 | 1 pulls the open-drain ready pin low; 0 leaves it released |
| mem_req | output | 1 | Request to internal store, held until granted |
| mem_we | output | 1 | Request direction, 1 = write |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Grant from internal store, may be combinational on mem_req |
| mem_rdata | input | DW | Read data, valid with the grant |

## Verification
The hardest situation to reach is a read whose strobe is already low at the pins while the store has not answered. Ready must then stay pulled and the data lines must stay undriven for exactly the grant delay, and only then turn on with the fresh value. The bench's store model takes a grant delay from each vector, from zero (combinational grant) up to six cycles. It counts ready-low samples against that delay, and a monitor flags any cycle with output enable and ready both active. Stale-address cases are forced by scrambling the address lines after the latch strobe or the falling strobe while the request is still waiting.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;
   typedef enum logic [1:0] {
      HB_SEP_PLAIN = 2'b00,
      HB_SEP_LATCH = 2'b01,
      HB_MUXED     = 2'b10,
      HB_SERIAL    = 2'b11
   } hb_mode_e;
endpackage

// File: rtl/hb_sync.sv
`timescale 1ns/1ps
// Register pipeline for a bundle of host pins; all bits share the same delay.
module hb_sync #(
   parameter int             W       = 8,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 0) begin : g_bad_depth
         $error("hb_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_pipe
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/hb_addr_latch.sv
`timescale 1ns/1ps
// Holds the address captured under the latch strobe.
module hb_addr_latch #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          use_latch,
   input  logic          muxed,
   input  logic          latch_s,
   input  logic [AW-1:0] addr_s,
   input  logic [DW-1:0] ad_s,
   output logic [AW-1:0] addr_q
);
   logic take;
   assign take = active && use_latch && latch_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= '0;
      else if (take) addr_q <= muxed ? ad_s[AW-1:0] : addr_s;
   end

   p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(active && latch_s) |=> $stable(addr_q))
      else $error("latched address changed without latch strobe");
endmodule

// File: rtl/hb_xfer.sv
`timescale 1ns/1ps
// Turns strobe edges into request/grant transactions, drives ready and read data.
module hb_xfer #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          direct,
   input  logic          rd_s,
   input  logic          wr_s,
   input  logic [AW-1:0] addr_direct,
   input  logic [AW-1:0] addr_latched,
   input  logic [DW-1:0] wdata_s,
   input  logic          mem_gnt,
   input  logic [DW-1:0] mem_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          rdy_pull,
   output logic          rd_oe,
   output logic [DW-1:0] rd_data
);
   logic rd_prev, wr_prev, rd_done;
   logic rd_fall, wr_fall, idle, start_rd, start_wr;

   assign rd_fall  = active && !rd_s && rd_prev;
   assign wr_fall  = active && !wr_s && wr_prev;
   assign idle     = !mem_req && !rd_done;
   assign start_rd = idle && rd_fall;
   assign start_wr = idle && wr_fall && !rd_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_prev <= 1'b1;
         wr_prev <= 1'b1;
      end else begin
         rd_prev <= rd_s;
         wr_prev <= wr_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_req   <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else if (start_rd || start_wr) begin
         mem_req   <= 1'b1;
         mem_we    <= start_wr;
         mem_addr  <= direct ? addr_direct : addr_latched;
         mem_wdata <= wdata_s;
      end else if (mem_req && mem_gnt) begin
         mem_req   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_done <= 1'b0;
         rd_data <= '0;
      end else if (mem_req && mem_gnt && !mem_we) begin
         rd_data <= mem_rdata;
         rd_done <= active && !rd_s;
      end else if (!active || rd_s) begin
         rd_done <= 1'b0;
      end
   end

   assign rdy_pull = mem_req && !mem_gnt;
   assign rd_oe    = active && !rd_s && rd_done;

   p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))
      else $error("request dropped or changed before grant");

   p_rdy_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_pull |-> mem_req && !mem_gnt)
      else $error("ready pulled without an outstanding request");

   p_oe_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_oe |-> !mem_req && !rdy_pull)
      else $error("data driven while access pending");
endmodule

// File: rtl/hostbus_front.sv
`timescale 1ns/1ps
module hostbus_front #(
   parameter int AW          = 8,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode_sel,
   input  logic          cs_n,
   input  logic          ale,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] ad_in,
   output logic [DW-1:0] ad_out,
   output logic          ad_oe,
   output logic          rdy_pull,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_gnt,
   input  logic [DW-1:0] mem_rdata
);
   import hb_pkg::*;

   localparam int           PW      = 4 + AW + DW;
   localparam logic [PW-1:0] PIN_RST = {1'b1, 1'b0, 1'b1, 1'b1, {(AW+DW){1'b0}}};

   generate
      if (AW > DW) begin : g_bad_width
         $error("hostbus_front: AW must fit on the data lines for multiplexed mode");
      end
      if (AW < 1 || DW < 1) begin : g_bad_size
         $error("hostbus_front: widths must be positive");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("hostbus_front: at least one input register stage is required");
      end
   endgenerate

   hb_mode_e      mode;
   logic [PW-1:0] pins_s;
   logic          cs_s, ale_s, rd_s, wr_s, active;
   logic [AW-1:0] addr_s, addr_q;
   logic [DW-1:0] ad_s;

   assign mode = hb_mode_e'(mode_sel);

   hb_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, ale, rd_n, wr_n, addr_in, ad_in}),
      .q     (pins_s)
   );

   assign {cs_s, ale_s, rd_s, wr_s, addr_s, ad_s} = pins_s;
   assign active = (mode != HB_SERIAL) && !cs_s;

   hb_addr_latch #(.AW(AW), .DW(DW)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .use_latch (mode != HB_SEP_PLAIN),
      .muxed     (mode == HB_MUXED),
      .latch_s   (ale_s),
      .addr_s    (addr_s),
      .ad_s      (ad_s),
      .addr_q    (addr_q)
   );

   hb_xfer #(.AW(AW), .DW(DW)) u_xfer (
      .clk          (clk),
      .rst_n        (rst_n),
      .active       (active),
      .direct       (mode == HB_SEP_PLAIN),
      .rd_s         (rd_s),
      .wr_s         (wr_s),
      .addr_direct  (addr_s),
      .addr_latched (addr_q),
      .wdata_s      (ad_s),
      .mem_gnt      (mem_gnt),
      .mem_rdata    (mem_rdata),
      .mem_req      (mem_req),
      .mem_we       (mem_we),
      .mem_addr     (mem_addr),
      .mem_wdata    (mem_wdata),
      .rdy_pull     (rdy_pull),
      .rd_oe        (ad_oe),
      .rd_data      (ad_out)
   );

   p_serial_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == HB_SERIAL) |-> !mem_req && !ad_oe && !rdy_pull)
      else $error("activity in serial mode");

   p_cs_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !$rose(mem_req))
      else $error("request started while deselected");
endmodule

// File: tb/hostbus_front_bench.sv
`timescale 1ns/1ps
module hostbus_front_bench;
   localparam int S = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic       cs_n = 1'b1, ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
   logic [7:0] addr_in = '0, ad_in = '0;
   logic [7:0] ad_out, mem_addr, mem_wdata, mem_rdata;
   logic       ad_oe, rdy_pull, mem_req, mem_we, mem_gnt;

   logic [7:0] store [256];
   logic [3:0] gnt_delay = '0;
   logic [3:0] gcnt;
   int         total = 0, bad = 0, acc_cnt = 0, oe_bad = 0;
   logic [7:0] got_data;
   bit         got_flag;
   int         stretch;
   bit         done = 0;

   always #2.5 clk = ~clk;

   hostbus_front #(.AW(8), .DW(8), .SYNC_STAGES(S)) u_hostbus_front (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .ale(ale),
      .rd_n(rd_n), .wr_n(wr_n), .addr_in(addr_in), .ad_in(ad_in),
      .ad_out(ad_out), .ad_oe(ad_oe), .rdy_pull(rdy_pull), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
   );

   // store model with programmable grant delay
   assign mem_gnt   = mem_req && (gcnt == gnt_delay);
   assign mem_rdata = store[mem_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) gcnt <= '0;
      else if (mem_req && !mem_gnt) gcnt <= gcnt + 4'd1;
      else gcnt <= '0;
      if (rst_n && mem_req && mem_gnt) begin
         acc_cnt <= acc_cnt + 1;
         if (mem_we) store[mem_addr] <= mem_wdata;
      end
   end

   always @(negedge clk) if (rst_n && ad_oe && rdy_pull) oe_bad++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic host_access(input logic [1:0] m, input bit we, input logic [7:0] a,
                              input logic [7:0] d, input logic [3:0] dl, input bit scramble);
      gnt_delay = dl;
      mode_sel  = m;
      got_flag  = 0;
      got_data  = '0;
      stretch   = 0;
      @(negedge clk);
      cs_n = 1'b0;
      if (m == 2'b10) begin
         ad_in = a; ale = 1'b1;
         repeat (2) @(negedge clk);
         ale = 1'b0;
      end else if (m == 2'b01 || m == 2'b11) begin
         addr_in = a; ale = 1'b1;
         repeat (2) @(negedge clk);
         ale = 1'b0; addr_in = ~a;
      end else begin
         addr_in = a;
      end
      ad_in = we ? d : 8'h00;
      if (we) wr_n = 1'b0; else rd_n = 1'b0;
      for (int n = 0; n < 60; n++) begin
         @(negedge clk);
         if (rdy_pull) stretch++;
         if (!we && ad_oe && !got_flag) begin
            got_flag = 1;
            got_data = ad_out;
         end
         if (scramble && n == S + 2) begin
            addr_in = ~a;
            ad_in   = 8'h3E;
         end
         if (n >= S + 4 && !rdy_pull && (we || got_flag || m == 2'b11 || cs_n)) break;
      end
      wr_n = 1'b1; rd_n = 1'b1; cs_n = 1'b1;
      repeat (S + 2) @(negedge clk);
   endtask

   // {mode[1:0], we, delay[3:0], addr[7:0], data_or_expected[7:0]}
   localparam logic [22:0] VEC [12] = '{
      {2'b00, 1'b1, 4'd0, 8'h10, 8'hA5},
      {2'b00, 1'b0, 4'd3, 8'h10, 8'hA5},
      {2'b01, 1'b1, 4'd2, 8'h21, 8'h3C},
      {2'b01, 1'b0, 4'd0, 8'h21, 8'h3C},
      {2'b10, 1'b1, 4'd0, 8'h32, 8'hC3},
      {2'b10, 1'b0, 4'd4, 8'h32, 8'hC3},
      {2'b10, 1'b1, 4'd5, 8'hFF, 8'h81},
      {2'b00, 1'b0, 4'd0, 8'hFF, 8'h81},
      {2'b01, 1'b1, 4'd0, 8'h00, 8'h7E},
      {2'b10, 1'b0, 4'd2, 8'h00, 8'h7E},
      {2'b00, 1'b1, 4'd6, 8'h44, 8'h01},
      {2'b01, 1'b0, 4'd1, 8'h44, 8'h01}
   };

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: run did not complete");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int acc0;
      for (int i = 0; i < 256; i++) store[i] = 8'(i) ^ 8'h5A;
      repeat (4) @(negedge clk);
      chk(!ad_oe,    "R9 oe in reset", ad_oe, 0);
      chk(!rdy_pull, "R9 ready in reset", rdy_pull, 0);
      chk(!mem_req,  "R9 req in reset", mem_req, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!ad_oe && !rdy_pull && !mem_req, "R9 idle after reset",
          {ad_oe, rdy_pull, mem_req}, 0);

      // table: back-to-back accesses in all three parallel modes (R3 R5 R6 R7 R8)
      for (int k = 0; k < 12; k++) begin
         logic [22:0] v;
         v    = VEC[k];
         acc0 = acc_cnt;
         host_access(v[22:21], v[20], v[15:8], v[7:0], v[19:16], 1'b0);
         chk(acc_cnt == acc0 + 1, "R5 one request per strobe", acc_cnt - acc0, 1);
         chk(stretch == int'(v[19:16]), "R7 ready low for grant delay",
             stretch, v[19:16]);
         if (v[20]) begin
            chk(store[v[15:8]] == v[7:0], "R6 write stored", store[v[15:8]], v[7:0]);
         end else begin
            chk(got_flag, "R8 read data driven", got_flag, 1);
            chk(got_data == v[7:0], "R8 R3 read value", got_data, v[7:0]);
         end
      end

      // R2: deselected strobes ignored
      acc0 = acc_cnt;
      begin
         gnt_delay = 0; mode_sel = 2'b00;
         @(negedge clk); addr_in = 8'h10; ad_in = 8'h00; wr_n = 1'b0;
         repeat (S + 6) @(negedge clk);
         chk(!ad_oe && !rdy_pull, "R2 no activity deselected", {ad_oe, rdy_pull}, 0);
         wr_n = 1'b1; rd_n = 1'b0;
         repeat (S + 6) @(negedge clk);
         chk(!ad_oe, "R2 no drive deselected", ad_oe, 0);
         rd_n = 1'b1;
         repeat (S + 2) @(negedge clk);
      end
      chk(acc_cnt == acc0, "R2 no request deselected", acc_cnt - acc0, 0);
      host_access(2'b00, 1'b0, 8'h10, 8'h00, 4'd0, 1'b0);
      chk(got_data == 8'hA5, "R2 location untouched", got_data, 8'hA5);

      // R1: serial mode idle
      acc0 = acc_cnt;
      host_access(2'b11, 1'b1, 8'h21, 8'h00, 4'd0, 1'b0);
      host_access(2'b11, 1'b0, 8'h21, 8'h00, 4'd0, 1'b0);
      chk(acc_cnt == acc0, "R1 no request in serial mode", acc_cnt - acc0, 0);
      chk(!got_flag && stretch == 0, "R1 no drive or ready in serial mode",
          {got_flag, 8'(stretch)}, 0);
      host_access(2'b01, 1'b0, 8'h21, 8'h00, 4'd0, 1'b0);
      chk(got_data == 8'h3C, "R1 location untouched", got_data, 8'h3C);

      // R4: plain mode address taken at strobe fall; lines scrambled while pending
      host_access(2'b00, 1'b1, 8'h55, 8'h99, 4'd5, 1'b1);
      chk(store[8'h55] == 8'h99, "R4 write address at fall", store[8'h55], 8'h99);
      chk(store[8'hAA] == 8'hF0, "R4 scrambled address untouched", store[8'hAA], 8'hF0);
      host_access(2'b00, 1'b0, 8'h55, 8'h00, 4'd4, 1'b1);
      chk(got_data == 8'h99, "R4 read address at fall", got_data, 8'h99);

      // R3: multiplexed latch held while data lines scrambled
      host_access(2'b10, 1'b0, 8'h32, 8'h00, 4'd6, 1'b1);
      chk(got_data == 8'hC3, "R3 multiplexed latch hold", got_data, 8'hC3);

      chk(oe_bad == 0, "R8 no drive while ready pulled", oe_bad, 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule